// File: doc/BRIEF.md
# Logarithmic-Depth Priority Selector

This block picks one data word out of a set of condition/data pairs. The pair with the lowest index whose condition bit is set wins, which is the same result an if / else-if chain gives when it tests condition 0 first. Any number of conditions may be set at the same time, and the priority result is kept in every case. No one-hot input is assumed.

A linear chain would put every pair in series. Here the pairs are instead split into a lower and an upper half, and each half is split again until single pairs remain. Every merge point gives a "found" flag and a candidate word. The lower side wins whenever its flag is set. The combinational depth therefore grows with the logarithm of the pair count.

When no condition is set, the output word is all zeros and the hit flag is low. The result can be registered, which adds one cycle of latency and is the default.

Top module: `prio_tree_mux`

## Requirements
- R1: With exactly one condition bit k set, the cycle after sampling shows `data_o` equal to word k and `hit_o` high. Word k occupies bits [k*DATA_W +: DATA_W] of `data_i`.
- R2: With several condition bits set, `data_o` equals the word of the lowest set index.
- R3: With no condition bit set, `data_o` is all zeros and `hit_o` is low.
- R4: With the output register enabled, the outputs change only at a rising clock edge. They show the inputs sampled at that edge, so the latency is one cycle.
- R5: While `rst_ni` is low, `data_o` is zero and `hit_o` is low.
- R6: Changing the data words of non-winning pairs, or the conditions above the winning index, leaves the outputs unchanged.
- R7: The extreme indices select correctly: index 0 set together with every other bit, and index N_PAIRS-1 set alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_i | input | N_PAIRS | Condition bits; bit 0 has the highest priority |
| data_i | input | N_PAIRS*DATA_W | Packed data words, word k at [k*DATA_W +: DATA_W] |
| data_o | output | DATA_W | Selected word, zero when nothing is selected |
| hit_o | output | 1 | High when any condition bit was set |

## Verification
The hardest case to reach from the ports is a winner deep in the upper half while several lower-priority bits are also set. When random 64-bit conditions are used as they are, bit 0 or a nearby bit almost always wins. To get around this, the stimulus ANDs several random words together so the set bits become sparse. It also masks off a random low prefix, which forces winners at every depth of the tree. Directed steps then sweep each single index, hold a fixed winner while the words and higher conditions around it churn, and drive the all-zero and all-ones condition patterns.

// File: rtl/prio_tree_pkg.sv
package prio_tree_pkg;
  localparam int unsigned DEF_PAIRS  = 64;
  localparam int unsigned DEF_DATA_W = 16;
endpackage

// File: rtl/prio_tree_node.sv
// Merge of two sub-results; lower-index side takes precedence.
module prio_tree_node #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              hit_lo_i,
  input  logic [DATA_W-1:0] val_lo_i,
  input  logic              hit_hi_i,
  input  logic [DATA_W-1:0] val_hi_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] val_o
);
  assign hit_o = hit_lo_i | hit_hi_i;
  assign val_o = hit_lo_i ? val_lo_i : val_hi_i;
endmodule

// File: rtl/prio_tree_sub.sv
// Recursive halving; a leaf gates its word so an empty subtree yields zero.
module prio_tree_sub #(
  parameter int unsigned N      = 64,
  parameter int unsigned DATA_W = 16
) (
  input  logic [N-1:0]        cond_i,
  input  logic [N*DATA_W-1:0] data_i,
  output logic                hit_o,
  output logic [DATA_W-1:0]   val_o
);
  if (N == 1) begin : g_leaf
    assign hit_o = cond_i[0];
    assign val_o = cond_i[0] ? data_i : '0;
  end else begin : g_split
    localparam int unsigned N_LO = N / 2;
    localparam int unsigned N_HI = N - N_LO;

    logic              hit_lo, hit_hi;
    logic [DATA_W-1:0] val_lo, val_hi;

    prio_tree_sub #(.N(N_LO), .DATA_W(DATA_W)) lo_i (
      .cond_i (cond_i[N_LO-1:0]),
      .data_i (data_i[N_LO*DATA_W-1:0]),
      .hit_o  (hit_lo),
      .val_o  (val_lo)
    );

    prio_tree_sub #(.N(N_HI), .DATA_W(DATA_W)) hi_i (
      .cond_i (cond_i[N-1:N_LO]),
      .data_i (data_i[N*DATA_W-1:N_LO*DATA_W]),
      .hit_o  (hit_hi),
      .val_o  (val_hi)
    );

    prio_tree_node #(.DATA_W(DATA_W)) node_i (
      .hit_lo_i (hit_lo),
      .val_lo_i (val_lo),
      .hit_hi_i (hit_hi),
      .val_hi_i (val_hi),
      .hit_o    (hit_o),
      .val_o    (val_o)
    );
  end
endmodule

// File: rtl/prio_tree_oreg.sv
module prio_tree_oreg #(
  parameter int unsigned DATA_W = 16,
  parameter bit          EN     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] val_o
);
  if (EN) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_o <= 1'b0;
        val_o <= '0;
      end else begin
        hit_o <= hit_i;
        val_o <= val_i;
      end
    end
  end else begin : g_pass
    assign hit_o = hit_i;
    assign val_o = val_i;
  end
endmodule

// File: rtl/prio_tree_mux.sv
module prio_tree_mux
  import prio_tree_pkg::*;
#(
  parameter int unsigned N_PAIRS = DEF_PAIRS,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_PAIRS-1:0]        cond_i,
  input  logic [N_PAIRS*DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]         data_o,
  output logic                      hit_o
);
  logic              tree_hit;
  logic [DATA_W-1:0] tree_val;

  prio_tree_sub #(.N(N_PAIRS), .DATA_W(DATA_W)) tree_i (
    .cond_i (cond_i),
    .data_i (data_i),
    .hit_o  (tree_hit),
    .val_o  (tree_val)
  );

  prio_tree_oreg #(.DATA_W(DATA_W), .EN(OUT_REG)) oreg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (tree_hit),
    .val_i  (tree_val),
    .hit_o  (hit_o),
    .val_o  (data_o)
  );
endmodule

// File: rtl/prio_tree_mux_chk.sv
module prio_tree_mux_chk #(
  parameter int unsigned N_PAIRS = 64,
  parameter int unsigned DATA_W  = 16,
  parameter bit          OUT_REG = 1'b1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_PAIRS-1:0]        cond_i,
  input logic [N_PAIRS*DATA_W-1:0] data_i,
  input logic [DATA_W-1:0]         data_o,
  input logic                      hit_o
);
  // Linear scan model, highest index first so the lowest set index ends last.
  logic [DATA_W-1:0] ref_val;
  always_comb begin
    ref_val = '0;
    for (int k = N_PAIRS - 1; k >= 0; k--) begin
      if (cond_i[k]) ref_val = data_i[k*DATA_W +: DATA_W];
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_clear_R5: assert (!hit_o && data_o == '0);
  end

  if (OUT_REG) begin : g_seq
    assert_hit_any_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|cond_i) |=> hit_o);
    assert_lowest_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> data_o == $past(ref_val));
    assert_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cond_i == '0) |=> (!hit_o && data_o == '0));
    assert_top_index_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cond_i[0] |=> data_o == $past(data_i[DATA_W-1:0]));
  end
endmodule

bind prio_tree_mux prio_tree_mux_chk #(
  .N_PAIRS(N_PAIRS), .DATA_W(DATA_W), .OUT_REG(OUT_REG)
) chk_i (.*);

// File: tb/prio_tree_mux_tb_top.sv
`timescale 1ns/1ps
module prio_tree_mux_tb_top;
  localparam int unsigned N  = 64;
  localparam int unsigned W  = 16;
  localparam int unsigned WD = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     cond = '0;
  logic [N*W-1:0]   data = '0;
  logic [W-1:0]     data_o;
  logic             hit_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [W-1:0] exp_v_prev = '0;
  logic         exp_h_prev = 1'b0;

  always #2 clk = ~clk;

  prio_tree_mux #(.N_PAIRS(N), .DATA_W(W), .OUT_REG(1'b1)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .cond_i (cond), .data_i (data),
    .data_o (data_o), .hit_o (hit_o)
  );

  function automatic logic [W-1:0] ref_pick(logic [N-1:0] c, logic [N*W-1:0] d);
    for (int k = 0; k < N; k++) if (c[k]) return d[k*W +: W];
    return '0;
  endfunction

  function automatic logic [N*W-1:0] rand_words();
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) r[k*W +: W] = W'($urandom);
    return r;
  endfunction

  function automatic logic [N-1:0] rand_cond();
    return {$urandom, $urandom};
  endfunction

  task automatic chk(string req, logic [W-1:0] ev, logic eh);
    checks++;
    if (data_o !== ev || hit_o !== eh) begin
      fails++;
      $display("FAIL %s: data_o=%h hit_o=%b expected data_o=%h hit_o=%b",
               req, data_o, hit_o, ev, eh);
    end
  endtask

  // Drive at negedge; check old value holds before the edge, new value after.
  task automatic apply(logic [N-1:0] c, logic [N*W-1:0] d, string req);
    logic [W-1:0] ev;
    cond = c;
    data = d;
    ev = ref_pick(c, d);
    #1;
    chk("R4", exp_v_prev, exp_h_prev);
    @(negedge clk);
    chk(req, ev, |c);
    exp_v_prev = ev;
    exp_h_prev = |c;
  endtask

  initial begin
    #(WD * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0]   c;
    logic [N*W-1:0] d;
    void'($urandom(32'd5171));
    data = rand_words();
    cond = '1;
    repeat (2) @(negedge clk);
    chk("R5", '0, 1'b0);  // reset dominates live inputs
    cond = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", '0, 1'b0);

    // R1: single index sweep
    for (int k = 0; k < N; k++) begin
      c = '0;
      c[k] = 1'b1;
      apply(c, rand_words(), "R1");
    end

    // R7: extreme indices
    apply('1, rand_words(), "R7");
    c = '0;
    c[N-1] = 1'b1;
    apply(c, rand_words(), "R7");

    // R3: nothing set, words busy
    for (int i = 0; i < 4; i++) apply('0, rand_words(), "R3");

    // R6: fixed winner, churn other words and higher conditions
    for (int k = 5; k < N; k += 13) begin
      d = rand_words();
      for (int i = 0; i < 6; i++) begin
        logic [N*W-1:0] d2;
        c = rand_cond();
        c &= ~((N'(1) << k) - N'(1));
        c[k] = 1'b1;
        d2 = rand_words();
        d2[k*W +: W] = d[k*W +: W];
        apply(c, d2, "R6");
      end
    end

    // R2: overlapping conditions, sparse and masked to spread winners
    for (int i = 0; i < 400; i++) begin
      int unsigned sh;
      c = rand_cond();
      if (i % 3 != 0) c &= rand_cond() & rand_cond();
      sh = $urandom_range(N - 1);
      if (i % 2 == 1) c &= ~((N'(1) << sh) - N'(1));
      apply(c, rand_words(), "R2");
    end

    // Reset mid-run clears outputs (R5)
    cond = '1;
    rst_n = 1'b0;
    #1;
    chk("R5", '0, 1'b0);
    @(negedge clk);
    chk("R5", '0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule